// File: doc/BRIEF.md
# Asynchronous SRAM Read Timing Sequencer

This block turns internal read requests into strobe-level read cycles on an external asynchronous SRAM. A request carries a bank number and a word address. Once accepted, the sequencer selects the bank, enables the outputs and drives the address for a setup interval. It then pulses the read strobe for an access interval and keeps the bank selected for a hold interval. The data word on the bus is captured on the edge that ends the access interval. It is handed back with a one-cycle valid pulse.

Each bank has its own four timing fields: setup, access, hold and turnaround. These are written through a simple register-write port. Two reads to the same bank can follow each other directly: when the second one is already waiting as the first one's hold ends, the bank stays selected and the next setup starts at once. In every other case the sequencer drops select and output enable for the bank's programmed number of turnaround cycles before it starts the next access.

Top module: `sram_rd_seq`

## Requirements
- R1: After reset every bank select, the output enable and the read strobe are high (all strobes are active low), `rd_valid` is low and `req_ready` is high.
- R2: A request accepted while the bus is idle starts its setup in the first cycle after the accepting edge. For setup+access+hold cycles, exactly the requested bank's `mem_sel_n` bit is low, `mem_oe_n` is low and `mem_addr` holds the request address.
- R3: `mem_re_n` is low for exactly the access-length cycles that follow the setup cycles, and is high in setup and hold.
- R4: `rd_data` takes the value of `mem_data` sampled on the edge where `mem_re_n` returns high. `rd_valid` is high for exactly one cycle, the first hold cycle.
- R5: When a hold ends and no request to the same bank is waiting, all selects and `mem_oe_n` stay high for the bank's turnaround count. A waiting request then starts its setup in the next cycle.
- R6: When a request to the same bank is waiting as a hold ends, the next setup begins in the following cycle, with no cycle in which the select or output enable goes high.
- R7: A setup, access or hold field of 0 acts as 1 cycle. A turnaround field of 0 inserts no idle cycle, and a waiting request to another bank starts right after the hold.
- R8: `req_ready` is high only while the sequencer is idle or in a hold cycle, and only when no accepted request is still waiting. It is low in setup, access and turnaround.
- R9: Each bank's timing is held in its own 4-bit fields (setup, access, hold, turnaround), written when `tim_we` is high. Reset values are 2, 4, 1 and 2 cycles. A write to one bank leaves the others unchanged.
- R10: A read uses the timing of its own bank, and the turnaround after a read uses the turnaround field of the bank just read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_we | input | 1 | Timing register write enable |
| tim_bank | input | 2 | Bank whose timing is written |
| tim_setup | input | 4 | Setup cycles to write |
| tim_access | input | 4 | Access cycles to write |
| tim_hold | input | 4 | Hold cycles to write |
| tim_idle | input | 4 | Turnaround cycles to write |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | 2 | Bank of the request |
| req_addr | input | 20 | Word address of the request |
| mem_sel_n | output | 4 | Per-bank select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_addr | output | 20 | Address bus |
| mem_data | input | 16 | Data bus from the memory |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse with `rd_data` |

## Verification
A bench monitor records every output once per cycle. The cycle of each result is predicted from the timing fields alone. Setup starts one cycle after the accepting edge, and the read strobe falls after the setup count. The capture and valid pulse fall setup+access cycles after the start. The next read starts setup+access+hold cycles later for the same bank, with the bank's turnaround added for any other case. Each check compares the recorded trace at exactly those indices, and it compares gaps only over the predicted turnaround span. The model memory drives a recognisable word only while the read strobe is low. Capture at any edge other than the one that ends the access therefore shows up as a wrong word.

// File: rtl/srsq_pkg.sv
// Shared types for the asynchronous SRAM read sequencer.
// Assumes timing fields are 4 bits wide; a zero length field means one cycle.
package srsq_pkg;
    localparam int TW = 4;

    typedef struct packed {
        logic [TW-1:0] setup;
        logic [TW-1:0] access;
        logic [TW-1:0] hold;
        logic [TW-1:0] idle;
    } tim_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACCESS = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    // Length in cycles of a setup/access/hold field: zero counts as one.
    function automatic logic [TW-1:0] eff_len(logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction
endpackage

// File: rtl/srsq_timing_regs.sv
// Per-bank timing register file with two read ports.
// One register per bank; a write updates only the addressed bank.
// Assumes writes come from a configuration source and may occur at any time.
module srsq_timing_regs
    import srsq_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int DEF_SETUP = 2,
    parameter int DEF_ACC   = 4,
    parameter int DEF_HOLD  = 1,
    parameter int DEF_IDLE  = 2,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] wbank,
    input  tim_t          wdata,
    input  logic [BW-1:0] rbank_a,
    input  logic [BW-1:0] rbank_b,
    output tim_t          rd_a,
    output tim_t          rd_b
);
    tim_t regs [NBANK];

    localparam tim_t DEF_TIM = '{setup:  TW'(DEF_SETUP), access: TW'(DEF_ACC),
                                 hold:   TW'(DEF_HOLD),  idle:   TW'(DEF_IDLE)};

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        // Holds bank i timing; loads on a write addressed to this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= DEF_TIM;
            else if (we && wbank == BW'(i))
                regs[i] <= wdata;
        end

        // R9
        wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wbank == BW'(i)) |=> (regs[i] == $past(wdata)));
        // R9
        other_bank_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!we || wbank != BW'(i)) |=> $stable(regs[i]));
    end

    // Read port selection for current and candidate bank.
    always_comb begin
        rd_a = regs[rbank_a];
        rd_b = regs[rbank_b];
    end
endmodule

// File: rtl/srsq_req_slot.sv
// Request acceptance and single waiting slot.
// Accepts a request only while the sequencer is open (idle or hold) and the slot
// is empty. Presents either the stored request or the one arriving this cycle
// as the candidate. A take from the sequencer consumes the candidate.
module srsq_req_slot #(
    parameter int BW = 2,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_i,
    input  logic          take_i,
    input  logic          req_valid,
    input  logic [BW-1:0] req_bank,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          cand_valid,
    output logic [BW-1:0] cand_bank,
    output logic [AW-1:0] cand_addr
);
    logic          pend_q;
    logic [BW-1:0] pbank_q;
    logic [AW-1:0] paddr_q;
    logic          accept;

    // Ready and candidate selection.
    always_comb begin
        req_ready  = open_i && !pend_q;
        accept     = req_valid && req_ready;
        cand_valid = pend_q || accept;
        cand_bank  = pend_q ? pbank_q : req_bank;
        cand_addr  = pend_q ? paddr_q : req_addr;
    end

    // Slot storage: cleared on take, loaded on an accept that is not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pbank_q <= '0;
            paddr_q <= '0;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q  <= 1'b1;
            pbank_q <= req_bank;
            paddr_q <= req_addr;
        end
    end

    // R8
    take_has_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> cand_valid);
endmodule

// File: rtl/srsq_phase_fsm.sv
// Read cycle phase sequencer.
// Walks setup, access and hold with a down counter loaded from the bank timing.
// It then either chains into a same-bank setup or runs the bank's turnaround.
// Assumes candidate timing is read for the candidate bank in the same cycle.
module srsq_phase_fsm
    import srsq_pkg::*;
#(
    parameter int BW = 2,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_valid,
    input  logic [BW-1:0] cand_bank,
    input  logic [AW-1:0] cand_addr,
    input  tim_t          tim_cur,
    input  tim_t          tim_cand,
    output phase_e        phase,
    output logic [BW-1:0] cur_bank,
    output logic [AW-1:0] cur_addr,
    output logic          take,
    output logic          cap,
    output logic          open_o
);
    phase_e        ph_q, ph_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [BW-1:0] bank_q, bank_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          last;

    assign phase    = ph_q;
    assign cur_bank = bank_q;
    assign cur_addr = addr_q;
    assign last     = (cnt_q == '0);
    assign open_o   = (ph_q == PH_IDLE) || (ph_q == PH_HOLD);

    // Next phase, count and latched request.
    always_comb begin
        ph_d   = ph_q;
        cnt_d  = cnt_q;
        bank_d = bank_q;
        addr_d = addr_q;
        take   = 1'b0;
        cap    = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                take = cand_valid;
            end
            PH_SETUP: begin
                if (last) begin
                    ph_d  = PH_ACCESS;
                    cnt_d = eff_len(tim_cur.access) - TW'(1);
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            PH_ACCESS: begin
                if (last) begin
                    ph_d  = PH_HOLD;
                    cap   = 1'b1;
                    cnt_d = eff_len(tim_cur.hold) - TW'(1);
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            PH_HOLD: begin
                if (last) begin
                    if (cand_valid && cand_bank == bank_q) begin
                        take = 1'b1;
                    end else if (tim_cur.idle == '0) begin
                        take = cand_valid;
                        if (!cand_valid) ph_d = PH_IDLE;
                    end else begin
                        ph_d  = PH_TURN;
                        cnt_d = tim_cur.idle - TW'(1);
                    end
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            PH_TURN: begin
                if (last) begin
                    take = cand_valid;
                    if (!cand_valid) ph_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            default: ph_d = PH_IDLE;
        endcase
        if (take) begin
            ph_d   = PH_SETUP;
            bank_d = cand_bank;
            addr_d = cand_addr;
            cnt_d  = eff_len(tim_cand.setup) - TW'(1);
        end
    end

    // Phase state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            bank_q <= '0;
            addr_q <= '0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            bank_q <= bank_d;
            addr_q <= addr_d;
        end
    end

    // R5
    turn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_TURN) |=> (ph_q inside {PH_TURN, PH_SETUP, PH_IDLE}));
    // R3
    access_from_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_q == PH_ACCESS) |-> ($past(ph_q) == PH_SETUP));
    // R2
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q inside {PH_SETUP, PH_ACCESS} || (ph_q == PH_HOLD && !last)) |=> $stable(addr_q));
endmodule

// File: rtl/srsq_capture.sv
// Read data capture: registers the data bus on the capture strobe and
// raises a one-cycle valid pulse with it.
// Assumes capture strobes never arrive on consecutive cycles.
module srsq_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    // Data register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (cap) rd_data <= bus_data;
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_rd_seq.sv
// Asynchronous SRAM read timing sequencer, top level.
// Decodes the phase state into active-low select, output-enable and read
// strobes. It wires the timing registers, the request slot, the phase
// sequencer and data capture together.
// Assumes a single external data bus shared by all banks.
module sram_rd_seq
    import srsq_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int DEF_SETUP = 2,
    parameter int DEF_ACC   = 4,
    parameter int DEF_HOLD  = 1,
    parameter int DEF_IDLE  = 2,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tim_we,
    input  logic [BW-1:0]    tim_bank,
    input  logic [TW-1:0]    tim_setup,
    input  logic [TW-1:0]    tim_access,
    input  logic [TW-1:0]    tim_hold,
    input  logic [TW-1:0]    tim_idle,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BW-1:0]    req_bank,
    input  logic [AW-1:0]    req_addr,
    output logic [NBANK-1:0] mem_sel_n,
    output logic             mem_oe_n,
    output logic             mem_re_n,
    output logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_data,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid
);
    tim_t          wr_tim, tim_cur, tim_cand;
    phase_e        phase;
    logic [BW-1:0] cur_bank, cand_bank;
    logic [AW-1:0] cur_addr, cand_addr;
    logic          cand_valid, take, cap, open_w, active;

    assign wr_tim = '{setup: tim_setup, access: tim_access, hold: tim_hold, idle: tim_idle};

    srsq_timing_regs #(
        .NBANK(NBANK), .DEF_SETUP(DEF_SETUP), .DEF_ACC(DEF_ACC),
        .DEF_HOLD(DEF_HOLD), .DEF_IDLE(DEF_IDLE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(tim_we), .wbank(tim_bank), .wdata(wr_tim),
        .rbank_a(cur_bank), .rbank_b(cand_bank), .rd_a(tim_cur), .rd_b(tim_cand)
    );

    srsq_req_slot #(.BW(BW), .AW(AW)) u_slot (
        .clk(clk), .rst_n(rst_n), .open_i(open_w), .take_i(take),
        .req_valid(req_valid), .req_bank(req_bank), .req_addr(req_addr),
        .req_ready(req_ready), .cand_valid(cand_valid),
        .cand_bank(cand_bank), .cand_addr(cand_addr)
    );

    srsq_phase_fsm #(.BW(BW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_bank(cand_bank),
        .cand_addr(cand_addr), .tim_cur(tim_cur), .tim_cand(tim_cand),
        .phase(phase), .cur_bank(cur_bank), .cur_addr(cur_addr),
        .take(take), .cap(cap), .open_o(open_w)
    );

    srsq_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(cap), .bus_data(mem_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Strobe decode from the registered phase.
    always_comb begin
        active   = phase inside {PH_SETUP, PH_ACCESS, PH_HOLD};
        mem_oe_n = !active;
        mem_re_n = (phase != PH_ACCESS);
        mem_addr = cur_addr;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        assign mem_sel_n[b] = !(active && cur_bank == BW'(b));
    end

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_sel_n));
    // R3
    re_inside_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re_n |-> (!mem_oe_n && $countones(~mem_sel_n) == 1));
    // R4
    cap_at_re_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_re_n) |-> rd_valid);
    // R8
    no_ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_re_n && ($countones(~mem_sel_n) == 0 || !mem_oe_n)));
endmodule

// File: tb/sram_rd_seq_test.sv
// Directed bench: a negedge monitor records every output into a trace; each
// scenario task issues requests and checks the trace at predicted indices.
module sram_rd_seq_test;
    localparam int CLK_P = 10;
    localparam int TMAX  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tim_we = 1'b0;
    logic [1:0]  tim_bank = '0;
    logic [3:0]  tim_setup = '0, tim_access = '0, tim_hold = '0, tim_idle = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [19:0] req_addr = '0;
    logic [3:0]  mem_sel_n;
    logic        mem_oe_n, mem_re_n;
    logic [19:0] mem_addr;
    logic [15:0] mem_data;
    logic [15:0] rd_data;
    logic        rd_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    sram_rd_seq uut (
        .clk(clk), .rst_n(rst_n), .tim_we(tim_we), .tim_bank(tim_bank),
        .tim_setup(tim_setup), .tim_access(tim_access), .tim_hold(tim_hold),
        .tim_idle(tim_idle), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_addr(req_addr), .mem_sel_n(mem_sel_n),
        .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n), .mem_addr(mem_addr),
        .mem_data(mem_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] word_of(logic [19:0] a);
        return a[15:0] ^ 16'hA55A ^ {12'h0, a[19:16]};
    endfunction

    // Memory model: drives a real word only while the read strobe is low.
    assign mem_data = mem_re_n ? 16'hDEAD : word_of(mem_addr);

    logic [3:0]  t_sel [TMAX];
    logic        t_oe [TMAX], t_re [TMAX], t_rv [TMAX], t_rdy [TMAX];
    logic [19:0] t_addr [TMAX];
    logic [15:0] t_rd [TMAX];
    int tidx = 0;

    always @(negedge clk) begin
        if (tidx < TMAX) begin
            t_sel[tidx] = mem_sel_n; t_oe[tidx] = mem_oe_n; t_re[tidx] = mem_re_n;
            t_rv[tidx] = rd_valid;   t_rdy[tidx] = req_ready;
            t_addr[tidx] = mem_addr; t_rd[tidx] = rd_data;
        end
        tidx = tidx + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idx(input int n);
        while (tidx <= n) @(negedge clk);
        #1;
    endtask

    task automatic prog(input logic [1:0] b, input logic [3:0] s, a, h, i);
        @(negedge clk); #1;
        tim_we = 1; tim_bank = b; tim_setup = s; tim_access = a; tim_hold = h; tim_idle = i;
        @(negedge clk); #1;
        tim_we = 0;
    endtask

    // Issues one request; returns the trace index of its first setup cycle
    // if it started from idle (cycle after the accepting edge).
    task automatic issue(input logic [1:0] b, input logic [19:0] a, output int acc_idx);
        @(negedge clk); #1;
        req_valid = 1; req_bank = b; req_addr = a;
        while (!req_ready) begin @(negedge clk); #1; end
        acc_idx = tidx;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    // Checks one read window starting at trace index st (R2, R3, R4).
    task automatic expect_read(input int st, input int b, input int s, a, h,
                               input logic [19:0] ad, input string tag);
        bit ok_sel = 1, ok_re = 1, ok_ad = 1;
        int bad = 0;
        wait_idx(st + s + a + h + 1);
        for (int c = 0; c < s + a + h; c++) begin
            int k = st + c;
            bit re_exp = !(c >= s && c < s + a);
            if (t_sel[k] != ~(4'b1 << b) || t_oe[k] != 1'b0) begin ok_sel = 0; bad = k; end
            if (t_re[k] != re_exp) ok_re = 0;
            if (t_addr[k] != ad) ok_ad = 0;
        end
        check(ok_sel, "R2", {tag, " select/oe window"}, t_sel[bad], ~(4'b1 << b));
        check(ok_re, "R3", {tag, " read strobe window"}, 0, 1);
        check(ok_ad, "R2", {tag, " address held"}, 0, ad);
        check(t_rv[st + s + a] == 1 && t_rd[st + s + a] == word_of(ad), "R4",
              {tag, " captured word"}, t_rd[st + s + a], word_of(ad));
        check(t_rv[st + s + a - 1] == 0 && t_rv[st + s + a + 1] == 0, "R4",
              {tag, " valid is one cycle"}, t_rv[st + s + a + 1], 0);
    endtask

    // Checks an idle gap of n cycles from index st (R5).
    task automatic expect_gap(input int st, input int n, input string req, input string tag);
        bit ok = 1;
        wait_idx(st + n);
        for (int k = st; k < st + n; k++)
            if (t_sel[k] != 4'hF || t_oe[k] != 1'b1 || t_re[k] != 1'b1) ok = 0;
        check(ok, req, {tag, " turnaround idle"}, 0, 4'hF);
    endtask

    task automatic t_reset();
        wait_idx(tidx);
        check(mem_sel_n == 4'hF && mem_oe_n && mem_re_n, "R1", "strobes high",
              {mem_sel_n, mem_oe_n, mem_re_n}, 6'h3F);
        check(rd_valid == 0, "R1", "valid low", rd_valid, 0);
        check(req_ready == 1, "R1", "ready high", req_ready, 1);
    endtask

    // Reference timing 2/4/1/2 on bank 0 from reset values (R9).
    task automatic t_single();
        int st;
        issue(2'd0, 20'h00100, st);
        expect_read(st, 0, 2, 4, 1, 20'h00100, "single");
        expect_gap(st + 7, 2, "R5", "single");
        check(t_sel[st - 1] == 4'hF, "R2", "no select before start", t_sel[st - 1], 4'hF);
    endtask

    // Same bank back to back: no gap, second starts at end of hold (R6, R8).
    task automatic t_same_bank();
        int st1, st2;
        bit ok = 1;
        issue(2'd0, 20'h00200, st1);
        issue(2'd0, 20'h00201, st2);
        check(st2 == st1 + 7, "R8", "accepted in hold", st2, st1 + 7);
        for (int k = st1; k < st1 + 6; k++) if (t_rdy[k]) ok = 0;
        check(ok, "R8", "ready low in setup/access", 1, 0);
        expect_read(st1, 0, 2, 4, 1, 20'h00200, "same1");
        expect_read(st1 + 7, 0, 2, 4, 1, 20'h00201, "same2");
        check(t_sel[st1 + 6] == 4'hE && t_sel[st1 + 7] == 4'hE && t_oe[st1 + 7] == 0,
              "R6", "select kept across", t_sel[st1 + 7], 4'hE);
        expect_gap(st1 + 14, 2, "R5", "same tail");
    endtask

    // Different bank queued in hold: bank 0 turnaround of 2 first (R5, R10).
    task automatic t_other_bank();
        int st1, st2;
        bit ok = 1;
        issue(2'd0, 20'h00300, st1);
        issue(2'd1, 20'h10301, st2);
        expect_read(st1, 0, 2, 4, 1, 20'h00300, "diff1");
        expect_gap(st1 + 7, 2, "R5", "diff");
        expect_read(st1 + 9, 1, 2, 4, 1, 20'h10301, "diff2");
        for (int k = st1 + 7; k < st1 + 9; k++) if (t_rdy[k]) ok = 0;
        check(ok, "R8", "ready low in turnaround", 1, 0);
    endtask

    // Bank 2: setup 0 acts as 1, access 3, hold 2, turnaround 0 (R7, R9, R10).
    task automatic t_zero_fields();
        int st1, st2;
        prog(2'd2, 4'd0, 4'd3, 4'd2, 4'd0);
        prog(2'd3, 4'd3, 4'd0, 4'd0, 4'd5);
        issue(2'd2, 20'h22222, st1);
        issue(2'd1, 20'h11111, st2);
        expect_read(st1, 2, 1, 3, 2, 20'h22222, "zero1");
        expect_read(st1 + 6, 1, 2, 4, 1, 20'h11111, "zero2");
        check(t_sel[st1 + 5] == 4'hB && t_sel[st1 + 6] == 4'hD, "R7",
              "no turnaround with idle 0", t_sel[st1 + 6], 4'hD);
        expect_gap(st1 + 13, 2, "R10", "bank1 own turnaround");
        // Bank 3: access and hold 0 act as 1; turnaround 5 cycles.
        issue(2'd3, 20'h33333, st1);
        expect_read(st1, 3, 3, 1, 1, 20'h33333, "zero3");
        expect_gap(st1 + 5, 5, "R10", "bank3");
        wait_idx(st1 + 11);
        check(t_rdy[st1 + 10] == 1, "R8", "ready after turnaround", t_rdy[st1 + 10], 1);
        // Bank 0 still at reset values after other banks were written.
        issue(2'd0, 20'h00400, st1);
        expect_read(st1, 0, 2, 4, 1, 20'h00400, "bank0 kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        t_reset();
        t_single();
        t_same_bank();
        t_other_bank();
        t_zero_fields();
        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule